// File: doc/BRIEF.md
# Multi-Master Region Permission Checker

This block decides, for each bus access, whether the access may proceed. It keeps a table of region descriptors. Each descriptor has an inclusive address window, a packed rights word and a tag word. The tag word carries a process identifier, a don't-care mask for that identifier and a valid flag. An access names its address, the master that issued it, its kind (read, write or execute), a supervisor/user flag and a process identifier. Every descriptor that covers the access contributes its permission. The access is granted if any of the covering descriptors allows it. An access that no descriptor covers, or that no covering descriptor allows, ends with an access error.

Software fills the descriptor table through a one-word write port. The same address selects a word for combinational readback. The verdict is registered and appears one clock after the request strobe. The first error is recorded in a set of capture registers: address, master, access kind and mode. That record stays until software clears it.

Top module: `region_guard`

## Requirements
- R1: A descriptor covers an access only when its valid flag (tag word bit 0) is set and start <= address <= end, with both bounds inclusive. An access that no descriptor covers ends with an error.
- R2: A request strobed at clock edge k produces its result after edge k+1. After that edge, rspValid is high and exactly one of rspGrant and rspError is high. In a cycle after an edge with no request, all three are low.
- R3: For master 0 in user mode, rights bits [2:0] enable read (bit 2), write (bit 1) and execute (bit 0).
- R4: For master 0 in supervisor mode, rights bits [4:3] select the permissions: 0 allows read, write and execute; 1 allows read and execute; 2 allows read and write; 3 reuses the user bits [2:0].
- R5: When rights bit 5 is set, a descriptor covers a master-0 access only if (reqPid & ~mask) == (pid & ~mask). The pid is taken from tag bits [31:24] and the mask from tag bits [23:16]. When rights bit 5 is clear, or the master is not 0, the pid plays no part.
- R6: Masters 4, 6 and 7 take their read and write enables from rights bits 25/24, 27/26 and 29/28 (read enable first in each pair). Their execute requests are always refused. Any other master ID is always refused.
- R7: When several descriptors cover an access, the access is granted if any one of them permits it.
- R8: The access kind code is 0 for read, 1 for write and 2 for execute. Code 3 is always refused.
- R9: On a refused access, when errValid is low and errClear is low, errValid rises and the address, master, kind and mode of the access are recorded with the response. They then hold through later errors until errClear, which drops errValid on the next edge.
- R10: The config address is {descriptor index, word}, with word 0 = start, 1 = end, 2 = rights, 3 = tag. Reserved bits are written as zero and read back as zero. In the rights word only bits [29:24] and [5:0] are kept. In the tag word only bits [31:16] and bit 0 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgWe | input | 1 | Descriptor word write strobe |
| cfgAddr | input | 5 | {descriptor index, word select} |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Readback of the selected word |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Access address |
| reqMaster | input | 3 | Master ID |
| reqType | input | 2 | Access kind code |
| reqSuper | input | 1 | 1 = supervisor mode |
| reqPid | input | 8 | Process identifier |
| rspValid | output | 1 | Result valid |
| rspGrant | output | 1 | Access allowed |
| rspError | output | 1 | Access refused |
| errClear | input | 1 | Clears the error record |
| errValid | output | 1 | Error record holds a fault |
| errAddr | output | 32 | Faulting address |
| errMaster | output | 3 | Faulting master |
| errType | output | 2 | Faulting access kind |
| errSuper | output | 1 | Faulting mode |

## Verification
A bad descriptor bit or a bad window compare shows up as a wrong grant or error on the very next clock after the request. Readback makes any corrupted stored word visible in the same cycle. A fault in the error-record control shows as a record that moves during its sticky period or that fails to appear with the refusal. Either is visible at the ports in the cycle that follows the offending edge.

// File: rtl/regchk_pkg.sv
package regchk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accType_e;

  typedef struct packed {
    logic cfgWrite;
    logic rspLoad;
    logic capture;
    logic clear;
  } ctrlStrobe_t;

  localparam logic [31:0] RIGHTS_KEEP = 32'h3F00_003F;

  // Permission of one descriptor's rights word for one access
  function automatic logic rightsPermit(input logic [31:0] rights,
                                        input logic [2:0]  master,
                                        input logic [1:0]  kind,
                                        input logic        isSuper);
    logic [2:0] rwx;
    logic       rdEn;
    logic       wrEn;
    logic       result;
    rwx    = rights[2:0];
    rdEn   = 1'b0;
    wrEn   = 1'b0;
    result = 1'b0;
    if (master == 3'd0) begin
      if (isSuper) begin
        unique case (rights[4:3])
          2'd0:    rwx = 3'b111;
          2'd1:    rwx = 3'b101;
          2'd2:    rwx = 3'b110;
          default: rwx = rights[2:0];
        endcase
      end
      unique case (accType_e'(kind))
        ACC_READ:  result = rwx[2];
        ACC_WRITE: result = rwx[1];
        ACC_EXEC:  result = rwx[0];
        default:   result = 1'b0;
      endcase
    end else begin
      unique case (master)
        3'd4:    begin rdEn = rights[25]; wrEn = rights[24]; end
        3'd6:    begin rdEn = rights[27]; wrEn = rights[26]; end
        3'd7:    begin rdEn = rights[29]; wrEn = rights[28]; end
        default: begin rdEn = 1'b0;       wrEn = 1'b0;       end
      endcase
      if (accType_e'(kind) == ACC_READ)       result = rdEn;
      else if (accType_e'(kind) == ACC_WRITE) result = wrEn;
      else                                    result = 1'b0;
    end
    return result;
  endfunction

endpackage

// File: rtl/regchk_ctrl.sv
module regchk_ctrl
  import regchk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic        reqValid,
  input  logic        allowNow,
  input  logic        errClear,
  output ctrlStrobe_t strobe,
  output logic        errValid
);

  logic errValidQ;

  always_comb begin
    strobe.cfgWrite = cfgWe;
    strobe.rspLoad  = reqValid;
    strobe.clear    = errClear;
    strobe.capture  = reqValid && !allowNow && !errValidQ && !errClear;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               errValidQ <= 1'b0;
    else if (strobe.clear)   errValidQ <= 1'b0;
    else if (strobe.capture) errValidQ <= 1'b1;
  end

  assign errValid = errValidQ;

endmodule

// File: rtl/regchk_datapath.sv
module regchk_datapath
  import regchk_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int ADDR_W   = 32,
  parameter int PID_W    = 8,
  localparam int IDX_W   = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W+1:0]  cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqMaster,
  input  logic [1:0]        reqType,
  input  logic              reqSuper,
  input  logic [PID_W-1:0]  reqPid,
  output logic              allowNow,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              rspError,
  output logic [ADDR_W-1:0] errAddr,
  output logic [2:0]        errMaster,
  output logic [1:0]        errType,
  output logic              errSuper
);

  localparam int PID_HI  = 31;
  localparam int MASK_HI = 31 - PID_W;
  localparam logic [31:0] TAG_KEEP =
    {{(2*PID_W){1'b1}}, {(31-2*PID_W){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] startQ  [NUM_DESC];
  logic [ADDR_W-1:0] endQ    [NUM_DESC];
  logic [31:0]       rightsQ [NUM_DESC];
  logic [31:0]       tagQ    [NUM_DESC];

  logic [IDX_W-1:0]    selIdx;
  logic [1:0]          selWord;
  logic [NUM_DESC-1:0] passVec;

  assign selIdx  = cfgAddr[IDX_W+1:2];
  assign selWord = cfgAddr[1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        startQ[i]  <= '0;
        endQ[i]    <= '0;
        rightsQ[i] <= '0;
        tagQ[i]    <= '0;
      end
    end else if (strobe.cfgWrite) begin
      unique case (selWord)
        2'd0: startQ[selIdx]  <= cfgWdata[ADDR_W-1:0];
        2'd1: endQ[selIdx]    <= cfgWdata[ADDR_W-1:0];
        2'd2: rightsQ[selIdx] <= cfgWdata & RIGHTS_KEEP;
        default: tagQ[selIdx] <= cfgWdata & TAG_KEEP;
      endcase
    end
  end

  always_comb begin
    unique case (selWord)
      2'd0:    cfgRdata = 32'(startQ[selIdx]);
      2'd1:    cfgRdata = 32'(endQ[selIdx]);
      2'd2:    cfgRdata = rightsQ[selIdx];
      default: cfgRdata = tagQ[selIdx];
    endcase
  end

  for (genvar g = 0; g < NUM_DESC; g++) begin : gDesc
    logic             inWindow;
    logic             pidMatch;
    logic             covers;
    logic [PID_W-1:0] careBits;
    always_comb begin
      inWindow = (reqAddr >= startQ[g]) && (reqAddr <= endQ[g]);
      careBits = ~tagQ[g][MASK_HI -: PID_W];
      pidMatch = ((reqPid ^ tagQ[g][PID_HI -: PID_W]) & careBits) == '0;
      covers   = tagQ[g][0] && inWindow &&
                 (pidMatch || !rightsQ[g][5] || (reqMaster != 3'd0));
    end
    assign passVec[g] = covers &&
                        rightsPermit(rightsQ[g], reqMaster, reqType, reqSuper);
  end

  assign allowNow = |passVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspGrant <= 1'b0;
      rspError <= 1'b0;
    end else begin
      rspValid <= strobe.rspLoad;
      rspGrant <= strobe.rspLoad && allowNow;
      rspError <= strobe.rspLoad && !allowNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errAddr   <= '0;
      errMaster <= '0;
      errType   <= '0;
      errSuper  <= 1'b0;
    end else if (strobe.capture) begin
      errAddr   <= reqAddr;
      errMaster <= reqMaster;
      errType   <= reqType;
      errSuper  <= reqSuper;
    end
  end

endmodule

// File: rtl/region_guard.sv
module region_guard
  import regchk_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int ADDR_W   = 32,
  parameter int PID_W    = 8,
  localparam int IDX_W   = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W+1:0]  cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqMaster,
  input  logic [1:0]        reqType,
  input  logic              reqSuper,
  input  logic [PID_W-1:0]  reqPid,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              rspError,
  input  logic              errClear,
  output logic              errValid,
  output logic [ADDR_W-1:0] errAddr,
  output logic [2:0]        errMaster,
  output logic [1:0]        errType,
  output logic              errSuper
);

  ctrlStrobe_t strobe;
  logic        allowNow;

  regchk_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .reqValid (reqValid),
    .allowNow (allowNow),
    .errClear (errClear),
    .strobe   (strobe),
    .errValid (errValid)
  );

  regchk_datapath #(
    .NUM_DESC (NUM_DESC),
    .ADDR_W   (ADDR_W),
    .PID_W    (PID_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgAddr   (cfgAddr),
    .cfgWdata  (cfgWdata),
    .cfgRdata  (cfgRdata),
    .reqAddr   (reqAddr),
    .reqMaster (reqMaster),
    .reqType   (reqType),
    .reqSuper  (reqSuper),
    .reqPid    (reqPid),
    .allowNow  (allowNow),
    .rspValid  (rspValid),
    .rspGrant  (rspGrant),
    .rspError  (rspError),
    .errAddr   (errAddr),
    .errMaster (errMaster),
    .errType   (errType),
    .errSuper  (errSuper)
  );

endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqMaster,
  input logic [1:0]        reqType,
  input logic              rspValid,
  input logic              rspGrant,
  input logic              rspError,
  input logic              errClear,
  input logic              errValid,
  input logic [ADDR_W-1:0] errAddr,
  input logic [2:0]        errMaster
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R2
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid && !rspGrant && !rspError); // R2
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspGrant, rspError}) == 1); // R2
  AST_NONCORE_NO_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqMaster != 3'd0 && reqType == 2'd2 |=> rspError); // R6
  AST_RSVD_KIND: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqType == 2'd3 |=> rspError); // R8
  AST_ERR_RECORDED: assert property (@(posedge clk) disable iff (!rstN)
    rspError && !$past(errClear) |-> errValid); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errValid && !errClear |=> errValid && $stable(errAddr) && $stable(errMaster)); // R9
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    errClear |=> !errValid); // R9

endmodule

bind region_guard region_guard_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqMaster (reqMaster),
  .reqType   (reqType),
  .rspValid  (rspValid),
  .rspGrant  (rspGrant),
  .rspError  (rspError),
  .errClear  (errClear),
  .errValid  (errValid),
  .errAddr   (errAddr),
  .errMaster (errMaster)
);

// File: tb/test_region_guard.sv
module test_region_guard;

  localparam int ND = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqMaster = '0;
  logic [1:0]  reqType = '0;
  logic        reqSuper = 1'b0;
  logic [7:0]  reqPid = '0;
  logic        rspValid, rspGrant, rspError;
  logic        errClear = 1'b0;
  logic        errValid;
  logic [31:0] errAddr;
  logic [2:0]  errMaster;
  logic [1:0]  errType;
  logic        errSuper;

  always #4 clk = ~clk;

  region_guard i_region_guard (.*);

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [31:0] mStart [ND];
  logic [31:0] mEnd   [ND];
  logic [31:0] mRight [ND];
  logic [31:0] mTag   [ND];

  bit          eValid = 1'b0;
  logic [31:0] eAddr = '0;
  logic [2:0]  eMaster = '0;
  logic [1:0]  eType = '0;
  logic        eSuper = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit permOf(logic [31:0] r, logic [2:0] m, logic [1:0] t, bit s);
    logic [2:0] rwx;
    if (t == 2'd3) return 1'b0;
    if (m == 3'd0) begin
      rwx = r[2:0];
      if (s) begin
        if (r[4:3] == 2'd0) rwx = 3'b111;
        if (r[4:3] == 2'd1) rwx = 3'b101;
        if (r[4:3] == 2'd2) rwx = 3'b110;
      end
      return rwx[2 - t];
    end
    if (t == 2'd2) return 1'b0;
    if (m == 3'd4) return t == 2'd0 ? r[25] : r[24];
    if (m == 3'd6) return t == 2'd0 ? r[27] : r[26];
    if (m == 3'd7) return t == 2'd0 ? r[29] : r[28];
    return 1'b0;
  endfunction

  function automatic bit expectAllow(logic [31:0] a, logic [2:0] m, logic [1:0] t, bit s, logic [7:0] p);
    bit ok = 1'b0;
    for (int i = 0; i < ND; i++) begin
      bit hit;
      hit = mTag[i][0] && a >= mStart[i] && a <= mEnd[i];
      if (m == 3'd0 && mRight[i][5] && (((p ^ mTag[i][31:24]) & ~mTag[i][23:16]) != 8'h00)) hit = 1'b0;
      if (hit && permOf(mRight[i], m, t, s)) ok = 1'b1;
    end
    return ok;
  endfunction

  task automatic cfgWrite(input int idx, input int word, input logic [31:0] data);
    cfgWe = 1'b1; cfgAddr = 5'(idx * 4 + word); cfgWdata = data;
    case (word)
      0: mStart[idx] = data;
      1: mEnd[idx] = data;
      2: mRight[idx] = data & 32'h3F00_003F;
      default: mTag[idx] = data & 32'hFFFF_0001;
    endcase
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgReadCheck(input int idx, input int word, input logic [31:0] exp);
    cfgAddr = 5'(idx * 4 + word);
    #1;
    check("R10 readback", {32'h0, cfgRdata}, {32'h0, exp});
  endtask

  task automatic doReq(input string tag, input logic [31:0] a, input logic [2:0] m,
                       input logic [1:0] t, input bit s, input logic [7:0] p, input bit clr);
    bit ok;
    ok = expectAllow(a, m, t, s, p);
    reqValid = 1'b1; reqAddr = a; reqMaster = m; reqType = t; reqSuper = s; reqPid = p;
    errClear = clr;
    if (clr) eValid = 1'b0;
    else if (!ok && !eValid) begin
      eValid = 1'b1; eAddr = a; eMaster = m; eType = t; eSuper = s;
    end
    @(negedge clk);
    reqValid = 1'b0; errClear = 1'b0;
    check(tag, {61'h0, rspValid, rspGrant, rspError}, {61'h0, 1'b1, ok, !ok});
    check("R9 record", {eValid ? {errAddr, errMaster, errType, errSuper} : 38'h0, 25'h0, errValid},
                       {eValid ? {eAddr, eMaster, eType, eSuper} : 38'h0, 25'h0, eValid});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seedVal;
    seedVal = 32'h5EED_0042;
    void'($urandom(seedVal));
    for (int i = 0; i < ND; i++) begin
      mStart[i] = '0; mEnd[i] = '0; mRight[i] = '0; mTag[i] = '0;
    end
    repeat (3) @(negedge clk);
    // reset state
    check("R2 reset outputs", {59'h0, rspValid, rspGrant, rspError, errValid, 1'b0}, 64'h0);
    cfgReadCheck(3, 2, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reserved bits dropped
    cfgWrite(2, 2, 32'hFFFF_FFFF);
    cfgReadCheck(2, 2, 32'h3F00_003F);
    cfgWrite(2, 3, 32'hFFFF_FFFF);
    cfgReadCheck(2, 3, 32'hFFFF_0001);
    cfgWrite(2, 0, 32'h1234_5678);
    cfgReadCheck(2, 0, 32'h1234_5678);
    cfgWrite(2, 3, 32'h0);

    // R1 inclusive window, descriptor 0
    cfgWrite(0, 0, 32'h0000_1000);
    cfgWrite(0, 1, 32'h0000_1FFF);
    cfgWrite(0, 2, 32'h0000_0007);
    cfgWrite(0, 3, 32'h0000_0001);
    doReq("R1 start bound", 32'h1000, 3'd0, 2'd0, 1'b0, 8'h0, 1'b0);
    doReq("R1 end bound", 32'h1FFF, 3'd0, 2'd1, 1'b0, 8'h0, 1'b0);
    doReq("R1 below start", 32'h0FFF, 3'd0, 2'd0, 1'b0, 8'h0, 1'b0);
    doReq("R9 held on second fault", 32'h2000, 3'd4, 2'd0, 1'b1, 8'h0, 1'b0);
    @(negedge clk);
    check("R2 idle after response", {61'h0, rspValid, rspGrant, rspError}, 64'h0);
    doReq("R9 clear", 32'h1500, 3'd0, 2'd2, 1'b0, 8'h0, 1'b1);
    cfgWrite(0, 3, 32'h0000_0000);
    doReq("R1 invalid descriptor", 32'h1500, 3'd0, 2'd0, 1'b0, 8'h0, 1'b0);
    doReq("R9 clear again", 32'h1500, 3'd0, 2'd0, 1'b0, 8'h0, 1'b1);
    cfgWrite(0, 3, 32'h0000_0001);

    // R3 user bits, R4 supervisor codes
    cfgWrite(0, 2, 32'h0000_0002);
    doReq("R3 user write only", 32'h1100, 3'd0, 2'd1, 1'b0, 8'h0, 1'b0);
    doReq("R3 user read denied", 32'h1100, 3'd0, 2'd0, 1'b0, 8'h0, 1'b1);
    cfgWrite(0, 2, 32'h0000_0018);
    doReq("R4 code3 reuses user", 32'h1100, 3'd0, 2'd0, 1'b1, 8'h0, 1'b1);
    cfgWrite(0, 2, 32'h0000_0008);
    doReq("R4 code1 no write", 32'h1100, 3'd0, 2'd1, 1'b1, 8'h0, 1'b1);
    doReq("R4 code1 exec", 32'h1100, 3'd0, 2'd2, 1'b1, 8'h0, 1'b0);
    cfgWrite(0, 2, 32'h0000_0010);
    doReq("R4 code2 no exec", 32'h1100, 3'd0, 2'd2, 1'b1, 8'h0, 1'b1);
    doReq("R8 kind 3 refused", 32'h1100, 3'd0, 2'd3, 1'b1, 8'h0, 1'b1);

    // R5 pid with mask
    cfgWrite(0, 2, 32'h0000_0027);
    cfgWrite(0, 3, 32'h5A03_0001);
    doReq("R5 pid masked match", 32'h1100, 3'd0, 2'd0, 1'b0, 8'h59, 1'b1);
    doReq("R5 pid mismatch", 32'h1100, 3'd0, 2'd0, 1'b0, 8'h5E, 1'b1);
    cfgWrite(0, 2, 32'h0000_0007);
    doReq("R5 pid ignored when off", 32'h1100, 3'd0, 2'd0, 1'b0, 8'h5E, 1'b1);

    // R6 other masters, R7 OR of covering descriptors
    cfgWrite(0, 2, 32'h0100_0007);
    cfgWrite(1, 0, 32'h0000_1800);
    cfgWrite(1, 1, 32'h0000_2800);
    cfgWrite(1, 2, 32'h0200_0000);
    cfgWrite(1, 3, 32'h0000_0001);
    doReq("R7 write via desc0", 32'h1900, 3'd4, 2'd1, 1'b0, 8'h0, 1'b1);
    doReq("R7 read via desc1", 32'h1900, 3'd4, 2'd0, 1'b0, 8'h0, 1'b1);
    doReq("R6 master4 read outside desc1", 32'h1100, 3'd4, 2'd0, 1'b0, 8'h0, 1'b1);
    doReq("R6 master4 exec", 32'h1900, 3'd4, 2'd2, 1'b0, 8'h0, 1'b1);
    doReq("R6 unknown master", 32'h1900, 3'd3, 2'd0, 1'b0, 8'h0, 1'b1);

    // random phase
    for (int i = 0; i < ND; i++) begin
      logic [31:0] st, w3;
      st = $urandom % 4096;
      cfgWrite(i, 0, st);
      cfgWrite(i, 1, st + ($urandom % 1024));
      cfgWrite(i, 2, $urandom);
      w3 = $urandom;
      w3[31:24] = 8'($urandom % 4);
      w3[0] = ($urandom % 4) != 0;
      cfgWrite(i, 3, w3);
    end
    for (int k = 0; k < 400; k++) begin
      logic [2:0] m;
      case ($urandom % 6)
        0, 1: m = 3'd0;
        2: m = 3'd4;
        3: m = 3'd6;
        4: m = 3'd7;
        default: m = 3'd3;
      endcase
      doReq("R7 random", $urandom % 5120, m, 2'($urandom), 1'($urandom),
            8'($urandom % 4), ($urandom % 16) == 0);
      if (k % 50 == 0) cfgReadCheck(k % ND, 2, mRight[k % ND]);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule